// File: doc/BRIEF.md
# Video DRAM Cycle Decoder

This block watches the control strobes of a multiport video DRAM and names each memory cycle as it unfolds. The decision is made in two steps. When the row strobe falls, the states of the column strobe, the transfer strobe, the combined write enable and the special-function line tell refresh cycles apart from write and load cycles. For write and load cycles, the special-function line is sampled again when the column strobe falls. That second sample picks the final cycle type.

The block also keeps the sticky state that refresh and load cycles change:
- a persistent write-per-bit flag, together with the stored write mask;
- a stop-point mode flag;
- a 4-bit stop-point code.

For every write it reports whether the write is masked and which mask is in effect. All strobes are active low and are sampled on `clk`, so each falling or rising edge is seen as a change between two consecutive samples.

Top module: `vdc_cycle_decoder`

## Requirements
- R1: After reset, `cyc_valid`, `cyc_pulse`, `pwpb_mode` and `stop_mode` are 0, and `stop_code` is 0.
- R2: The combined write enable counts as low when `wel_n`, `weu_n` or both are low.
- R3: If `cas_n` is low when `ras_n` falls, the cycle is a refresh and `trg_n` is ignored. `cyc_type` is formed as {1'b0, write enable high, dsf}:
  - 0: reserved
  - 1: stop-point set
  - 2: option reset
  - 3: no-reset refresh

  `cyc_valid` and `cyc_pulse` rise one clock after the sample in which `ras_n` falls.
- R4: A stop-point-set refresh sets `stop_mode` and loads `stop_code` from `addr_code`, which carries address lines 7 down to 4.
- R5: An option-reset refresh clears `pwpb_mode` and `stop_mode` and keeps `stop_code`. A reserved refresh and a no-reset refresh change no mode state.
- R6: If `cas_n`, `trg_n` and `dsf` are high, high and low when `ras_n` falls, the cycle is a write. `dsf` at the `cas_n` fall gives type 4 (write) when low and 5 (block write) when high. `wr_masked` equals the combined write enable being low at the `ras_n` fall. The result appears one clock after the sample in which `cas_n` falls.
- R7: If `cas_n`, `trg_n`, the combined write enable and `dsf` are all high when `ras_n` falls, `dsf` at the `cas_n` fall gives type 6 (load write mask) when low and 7 (load colour) when high.
- R8: A load-write-mask cycle stores `dq` from the `cas_n` fall as the write mask and sets `pwpb_mode`. Only an option-reset refresh clears `pwpb_mode`.
- R9: `eff_mask` on a write is as follows:
  - unmasked write: all ones;
  - masked write with `pwpb_mode` clear: `dq` from the `ras_n` fall;
  - masked write with `pwpb_mode` set: the stored write mask.
- R10: `cyc_type` and `cyc_valid` hold until the sample in which `ras_n` rises, and `cyc_valid` is 0 from the next clock on. `cyc_pulse` is high for exactly one clock per decode.
- R11: A cycle with `trg_n` low and `cas_n` high at the `ras_n` fall produces no decode. So does a cycle with `cas_n` and `trg_n` high, `dsf` high and the write enable low.
- R12: If `cas_n` falls in the same sample in which `ras_n` rises, the end of the cycle wins and nothing is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| trg_n | input | 1 | Transfer/output strobe |
| wel_n | input | 1 | Lower-byte write enable |
| weu_n | input | 1 | Upper-byte write enable |
| dsf | input | 1 | Special-function select |
| addr_code | input | 4 | Address lines 7..4, source of the stop-point code |
| dq | input | 16 | Data bus |
| cyc_type | output | 3 | Decoded cycle type |
| cyc_valid | output | 1 | Decoded type is valid |
| cyc_pulse | output | 1 | One-clock strobe for each new decode |
| wr_masked | output | 1 | Current write is masked |
| eff_mask | output | 16 | Write mask in effect for the current write |
| pwpb_mode | output | 1 | Persistent write-per-bit mode |
| stop_mode | output | 1 | Stop-point mode |
| stop_code | output | 4 | Stored stop-point code |

## Verification
Two kinds of collision are exercised.

The first is between reading and writing the persistent state. A masked write that follows a load-write-mask cycle must choose its mask from the flag as it stood before that write. Likewise, an option-reset refresh must clear a flag that an earlier cycle set. The bench provokes this by sweeping every strobe combination twice in a row. A bench-side model of the flag, the mask and the stop-point state carries over from one cycle to the next.

The second collision is a column-strobe fall in the same sample as the row strobe rising. It is provoked with a deliberately late `cas_n`. It is judged by `cyc_valid` and `cyc_pulse` staying low.

// File: rtl/vdc_pkg.sv
package vdc_pkg;

  typedef enum logic [2:0] {
    CY_RSVD     = 3'd0,
    CY_REF_STOP = 3'd1,
    CY_REF_CLR  = 3'd2,
    CY_REF_KEEP = 3'd3,
    CY_WR       = 3'd4,
    CY_BLKWR    = 3'd5,
    CY_LD_MASK  = 3'd6,
    CY_LD_COLOR = 3'd7
  } cyc_e;

  typedef enum logic [1:0] {
    PD_NONE  = 2'd0,
    PD_WRITE = 2'd1,
    PD_LOAD  = 2'd2
  } pend_e;

endpackage

// File: rtl/vdc_strobe_edges.sv
module vdc_strobe_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  input  logic cas_n,
  output logic ras_fall,
  output logic ras_rise,
  output logic cas_fall
);

  logic ras_q, cas_q;

  // Strobes idle high, so the history registers reset high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q <= 1'b1;
      cas_q <= 1'b1;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
    end
  end

  assign ras_fall = ras_q & ~ras_n;
  assign ras_rise = ~ras_q & ras_n;
  assign cas_fall = cas_q & ~cas_n;

endmodule

// File: rtl/vdc_ras_classify.sv
module vdc_ras_classify
  import vdc_pkg::*;
(
  input  logic  cas_n,
  input  logic  trg_n,
  input  logic  we_low,
  input  logic  dsf,
  output logic  is_refresh,
  output cyc_e  ref_type,
  output pend_e pend
);

  // First decode stage, evaluated on the row-strobe fall.
  always_comb begin
    is_refresh = 1'b0;
    ref_type   = CY_RSVD;
    pend       = PD_NONE;
    if (!cas_n) begin
      is_refresh = 1'b1;
      ref_type   = cyc_e'({1'b0, ~we_low, dsf});
    end else if (trg_n) begin
      if (!dsf)         pend = PD_WRITE;
      else if (!we_low) pend = PD_LOAD;
    end
  end

endmodule

// File: rtl/vdc_mode_regs.sv
module vdc_mode_regs #(
  parameter int DQ_W   = 16,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_stop,
  input  logic [CODE_W-1:0] code_in,
  input  logic              clr_modes,
  input  logic              load_mask,
  input  logic [DQ_W-1:0]   mask_in,
  output logic              pwpb,
  output logic              stop_mode,
  output logic [CODE_W-1:0] stop_code,
  output logic [DQ_W-1:0]   wmask
);

  logic              pwpb_d, stop_d;
  logic [CODE_W-1:0] code_d;
  logic [DQ_W-1:0]   wmask_d;
  logic              en;

  assign en = set_stop | clr_modes | load_mask;

  always_comb begin
    pwpb_d  = pwpb;
    stop_d  = stop_mode;
    code_d  = stop_code;
    wmask_d = wmask;
    if (clr_modes) begin
      pwpb_d = 1'b0;
      stop_d = 1'b0;
    end
    if (set_stop) begin
      stop_d = 1'b1;
      code_d = code_in;
    end
    if (load_mask) begin
      pwpb_d  = 1'b1;
      wmask_d = mask_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwpb      <= 1'b0;
      stop_mode <= 1'b0;
      stop_code <= '0;
      wmask     <= '0;
    end else if (en) begin
      pwpb      <= pwpb_d;
      stop_mode <= stop_d;
      stop_code <= code_d;
      wmask     <= wmask_d;
    end
  end

endmodule

// File: rtl/vdc_cycle_decoder.sv
module vdc_cycle_decoder
  import vdc_pkg::*;
#(
  parameter int DQ_W   = 16,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              trg_n,
  input  logic              wel_n,
  input  logic              weu_n,
  input  logic              dsf,
  input  logic [CODE_W-1:0] addr_code,
  input  logic [DQ_W-1:0]   dq,
  output logic [2:0]        cyc_type,
  output logic              cyc_valid,
  output logic              cyc_pulse,
  output logic              wr_masked,
  output logic [DQ_W-1:0]   eff_mask,
  output logic              pwpb_mode,
  output logic              stop_mode,
  output logic [CODE_W-1:0] stop_code
);

  localparam logic [DQ_W-1:0] ALL_ONES = {DQ_W{1'b1}};

  // Reset: asserts asynchronously, releases on a clock edge.
  logic [1:0] rst_sync;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end

  assign rst_i_n = rst_sync[1];

  logic ras_fall, ras_rise, cas_fall;

  vdc_strobe_edges u_edges (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .ras_fall (ras_fall),
    .ras_rise (ras_rise),
    .cas_fall (cas_fall)
  );

  logic  we_low;
  logic  is_ref;
  cyc_e  ref_type;
  pend_e cls_pend;

  assign we_low = ~(wel_n & weu_n);

  vdc_ras_classify u_cls (
    .cas_n      (cas_n),
    .trg_n      (trg_n),
    .we_low     (we_low),
    .dsf        (dsf),
    .is_refresh (is_ref),
    .ref_type   (ref_type),
    .pend       (cls_pend)
  );

  // Register state and its next-state values
  pend_e           pend_q, pend_d;
  logic            pmask_q, pmask_d;
  logic [DQ_W-1:0] rmask_q, rmask_d;
  cyc_e            type_q, type_d;
  logic            valid_q, valid_d;
  logic            pulse_q, pulse_d;
  logic            wm_q, wm_d;
  logic [DQ_W-1:0] emask_q, emask_d;

  logic            pwpb;
  logic [DQ_W-1:0] wmask;

  // Second stage fires on a column-strobe fall inside an open row cycle.
  logic cas_go;
  assign cas_go = cas_fall & ~ras_n & ~ras_fall & (pend_q != PD_NONE);

  logic set_stop, clr_modes, load_mask;
  assign set_stop  = ras_fall & is_ref & (ref_type == CY_REF_STOP);
  assign clr_modes = ras_fall & is_ref & (ref_type == CY_REF_CLR);
  assign load_mask = cas_go & (pend_q == PD_LOAD) & ~dsf;

  vdc_mode_regs #(.DQ_W(DQ_W), .CODE_W(CODE_W)) u_modes (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .set_stop  (set_stop),
    .code_in   (addr_code),
    .clr_modes (clr_modes),
    .load_mask (load_mask),
    .mask_in   (dq),
    .pwpb      (pwpb),
    .stop_mode (stop_mode),
    .stop_code (stop_code),
    .wmask     (wmask)
  );

  always_comb begin
    pend_d  = pend_q;
    pmask_d = pmask_q;
    rmask_d = rmask_q;
    type_d  = type_q;
    valid_d = valid_q;
    pulse_d = 1'b0;
    wm_d    = wm_q;
    emask_d = emask_q;
    if (ras_rise) begin
      valid_d = 1'b0;
      pend_d  = PD_NONE;
    end else if (ras_fall) begin
      if (is_ref) begin
        type_d  = ref_type;
        valid_d = 1'b1;
        pulse_d = 1'b1;
        wm_d    = 1'b0;
        emask_d = ALL_ONES;
        pend_d  = PD_NONE;
      end else begin
        pend_d  = cls_pend;
        pmask_d = we_low;
        rmask_d = dq;
        valid_d = 1'b0;
      end
    end else if (cas_go) begin
      valid_d = 1'b1;
      pulse_d = 1'b1;
      pend_d  = PD_NONE;
      if (pend_q == PD_WRITE) begin
        type_d  = dsf ? CY_BLKWR : CY_WR;
        wm_d    = pmask_q;
        emask_d = !pmask_q ? ALL_ONES : (pwpb ? wmask : rmask_q);
      end else begin
        type_d  = dsf ? CY_LD_COLOR : CY_LD_MASK;
        wm_d    = 1'b0;
        emask_d = ALL_ONES;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      pend_q  <= PD_NONE;
      pmask_q <= 1'b0;
      rmask_q <= '0;
      type_q  <= CY_RSVD;
      valid_q <= 1'b0;
      pulse_q <= 1'b0;
      wm_q    <= 1'b0;
      emask_q <= ALL_ONES;
    end else begin
      pend_q  <= pend_d;
      pmask_q <= pmask_d;
      rmask_q <= rmask_d;
      type_q  <= type_d;
      valid_q <= valid_d;
      pulse_q <= pulse_d;
      wm_q    <= wm_d;
      emask_q <= emask_d;
    end
  end

  assign cyc_type  = type_q;
  assign cyc_valid = valid_q;
  assign cyc_pulse = pulse_q;
  assign wr_masked = wm_q;
  assign eff_mask  = emask_q;
  assign pwpb_mode = pwpb;

endmodule

// File: rtl/vdc_cycle_checker.sv
module vdc_cycle_checker #(
  parameter int DQ_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ras_n,
  input logic [2:0]      cyc_type,
  input logic            cyc_valid,
  input logic            cyc_pulse,
  input logic            wr_masked,
  input logic [DQ_W-1:0] eff_mask,
  input logic            pwpb_mode,
  input logic            stop_mode
);

  assert_pulse_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_pulse |-> cyc_valid);

  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_pulse |=> !cyc_pulse);

  assert_idle_row_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && $past(ras_n)) |-> !cyc_valid);

  assert_stop_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_mode) |-> (cyc_pulse && cyc_type == 3'd1));

  assert_pwpb_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwpb_mode) |-> (cyc_pulse && cyc_type == 3'd6));

  assert_pwpb_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwpb_mode) |-> (cyc_pulse && cyc_type == 3'd2));

  assert_unmasked_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_pulse && cyc_type[2:1] == 2'b10 && !wr_masked) |-> (&eff_mask));

endmodule

bind vdc_cycle_decoder vdc_cycle_checker #(.DQ_W(DQ_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ras_n     (ras_n),
  .cyc_type  (cyc_type),
  .cyc_valid (cyc_valid),
  .cyc_pulse (cyc_pulse),
  .wr_masked (wr_masked),
  .eff_mask  (eff_mask),
  .pwpb_mode (pwpb_mode),
  .stop_mode (stop_mode)
);

// File: tb/vdc_cycle_decoder_tb.sv
module vdc_cycle_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ras_n, cas_n, trg_n, wel_n, weu_n, dsf;
  logic [3:0]  addr_code;
  logic [15:0] dq;
  logic [2:0]  cyc_type;
  logic        cyc_valid, cyc_pulse, wr_masked, pwpb_mode, stop_mode;
  logic [15:0] eff_mask;
  logic [3:0]  stop_code;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // Model of the sticky state
  bit        m_pwpb = 0, m_stop = 0;
  bit [3:0]  m_code = 0;
  bit [15:0] m_wmask = 0;

  always #10 clk = ~clk;

  vdc_cycle_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .trg_n(trg_n),
    .wel_n(wel_n), .weu_n(weu_n), .dsf(dsf), .addr_code(addr_code), .dq(dq),
    .cyc_type(cyc_type), .cyc_valid(cyc_valid), .cyc_pulse(cyc_pulse),
    .wr_masked(wr_masked), .eff_mask(eff_mask), .pwpb_mode(pwpb_mode),
    .stop_mode(stop_mode), .stop_code(stop_code)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_modes(input string req);
    chk(pwpb_mode == m_pwpb, {req, " pwpb"}, pwpb_mode, m_pwpb);
    chk(stop_mode == m_stop, {req, " stop"}, stop_mode, m_stop);
    chk(stop_code == m_code, {req, " code"}, stop_code, m_code);
  endtask

  task automatic idle_inputs();
    ras_n = 1; cas_n = 1; trg_n = 1; wel_n = 1; weu_n = 1; dsf = 0;
    addr_code = 0; dq = 0;
  endtask

  task automatic run_cycle(input bit cas_first, input bit t, input bit wl,
                           input bit wu, input bit d_r, input bit d_c,
                           input logic [3:0] a, input logic [15:0] q_r,
                           input logic [15:0] q_c);
    bit        we_low, recog, is_wr;
    bit [2:0]  e_type;
    bit [15:0] e_mask;
    we_low = !wl || !wu;            // R2
    recog = 0; is_wr = 0; e_type = 0; e_mask = 16'hFFFF;
    @(negedge clk);
    if (cas_first) cas_n = 0;
    @(negedge clk);
    ras_n = 0; trg_n = t; wel_n = wl; weu_n = wu; dsf = d_r;
    addr_code = a; dq = q_r;
    @(negedge clk);
    if (cas_first) begin
      e_type = {1'b0, !we_low, d_r};  // R3
      if (e_type == 3'd1) begin m_stop = 1; m_code = a; end   // R4
      if (e_type == 3'd2) begin m_pwpb = 0; m_stop = 0; end   // R5
      chk(cyc_valid && cyc_pulse, "R3 refresh valid", {cyc_valid, cyc_pulse}, 2'b11);
      chk(cyc_type == e_type, "R3 refresh type", cyc_type, e_type);
      chk_modes("R4/R5");
      recog = 1;
    end else begin
      chk(!cyc_valid, "R6 no early decode", cyc_valid, 0);
      cas_n = 0; dsf = d_c; dq = q_c;
      @(negedge clk);
      if (t && !d_r) begin
        recog = 1; is_wr = 1;
        e_type = d_c ? 3'd5 : 3'd4;                           // R6
        e_mask = !we_low ? 16'hFFFF : (m_pwpb ? m_wmask : q_r); // R9
      end else if (t && d_r && !we_low) begin
        recog = 1;
        e_type = d_c ? 3'd7 : 3'd6;                           // R7
        if (!d_c) begin m_pwpb = 1; m_wmask = q_c; end        // R8
      end
      if (recog) begin
        chk(cyc_valid && cyc_pulse, "R6/R7 decode valid", {cyc_valid, cyc_pulse}, 2'b11);
        chk(cyc_type == e_type, "R6/R7 type", cyc_type, e_type);
        if (is_wr) begin
          chk(wr_masked == we_low, "R6 masked", wr_masked, we_low);
          chk(eff_mask == e_mask, "R9 eff_mask", eff_mask, e_mask);
        end
        chk_modes("R8");
      end else begin
        chk(!cyc_valid && !cyc_pulse, "R11 no decode", {cyc_valid, cyc_pulse}, 0);
        chk_modes("R11");
      end
    end
    @(negedge clk);
    chk(!cyc_pulse, "R10 pulse one clock", cyc_pulse, 0);
    chk(cyc_valid == recog, "R10 valid held", cyc_valid, recog);
    if (recog) chk(cyc_type == e_type, "R10 type held", cyc_type, e_type);
    idle_inputs();
    @(negedge clk);
    chk(!cyc_valid, "R10 valid drop", cyc_valid, 0);
  endtask

  initial begin
    #(20 * 20000);
    chk(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1
    chk(!cyc_valid && !cyc_pulse, "R1 reset outputs", {cyc_valid, cyc_pulse}, 0);
    chk_modes("R1");

    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 64; i++) begin
        run_cycle(i[5], i[4], i[3], i[2], i[1], i[0],
                  4'(i * 7 + pass * 3 + 1),
                  16'(i * 16'h1357 + pass * 16'h0F0F + 16'h0A5C),
                  16'(i * 16'h2B71 + pass * 16'h3C3C + 16'hC3A1));
      end
    end

    // Targeted: load mask, then a masked write must use the stored mask.
    run_cycle(0, 1, 1, 1, 1, 0, 4'h0, 16'h0000, 16'hBEEF);
    run_cycle(0, 1, 0, 1, 0, 0, 4'h0, 16'h1234, 16'h0000);
    // Option reset, then the masked write must use the bus mask again.
    run_cycle(1, 0, 1, 1, 0, 0, 4'h0, 16'h0000, 16'h0000);
    run_cycle(0, 1, 1, 0, 0, 1, 4'h0, 16'h5A5A, 16'h0000);

    // R12: column strobe falls in the same sample as the row strobe rises.
    @(negedge clk);
    ras_n = 0; trg_n = 1; dsf = 0;
    @(negedge clk);
    ras_n = 1; cas_n = 0;
    @(negedge clk);
    chk(!cyc_valid && !cyc_pulse, "R12 late cas", {cyc_valid, cyc_pulse}, 0);
    @(negedge clk);
    chk(!cyc_valid, "R12 stays idle", cyc_valid, 0);
    idle_inputs();
    @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule